// File: doc/BRIEF.md
# Dual-Die NAND Read-Path Target

This block is a synthesizable stand-in for a small read-only NAND-style flash part that sits on a host's parallel bus. The host drives two active-low die enables, a command latch, an address latch, active-low read and write strobes and an 8-bit data byte. All bus inputs are brought into the model clock domain through a two-stage synchronizer. Commands and address bytes are captured when the write strobe rises. Read data is driven while the read strobe is low, and the byte pointer advances when the read strobe rises. The shared bidirectional data lines are split into `din` and `dout`/`dout_en`.

Each of the two dies has its own read state machine, its own address-cycle counter, its own byte pointer and its own storage array. The array holds `PAGES` pages of 528 bytes each. It resets either to the erased value 0xFF or, for bring-up and test, to a computed address pattern. The byte pointer addresses the array linearly. The read mode sets a starting column of 0, 256 or 512. The second address byte steps by 256 pages and the third by one page, and the pointer wraps modulo the array size.

The per-die state machine has four states. `ST_IDLE` is entered from reset, from command 0xFF, from any unknown command and from any illegal address cycle. `ST_READ_LO` is entered on command 0x00, `ST_READ_MID` on command 0x01 and `ST_READ_HI` on command 0x50. Each of these three transitions is legal from any state. An unknown command or an illegal address byte also sets that die's sticky error flag.

Top module: `nand_rd_target`

## Requirements
- R1: Die 0 is selected when `ce_n[0]` is 0. Die 1 is selected only when `ce_n[0]` is 1 and `ce_n[1]` is 0. With `ce_n` = 2'b11, bus activity changes no pointer, state or error flag, and `dout_en` stays 0.
- R2: A command byte is latched from `din` on a rising `we_n` while `cle` is 1. The codes are: 0xFF goes to idle, 0x00 to read-low, 0x01 to read-mid and 0x50 to read-high.
- R3: The first address byte after a read-mode command loads the pointer with the byte plus a column of 0 (read-low), 256 (read-mid) or 512 (read-high).
- R4: The second address byte adds byte×528×256 and the third adds byte×528. All pointer arithmetic is modulo N = PAGES×528.
- R5: Each rising `re_n` on a selected die with both latches low advances that die's pointer by one, and the pointer wraps from N−1 to 0.
- R6: `dout_en` is 1 only while a die is selected, `re_n` is 0 and both latches are 0. `dout` then carries the selected die's byte at its pointer, and it is 0 otherwise.
- R7: While a die is selected and both `re_n` and `we_n` are 1, `ready` carries a 1 in that die's bit position (bit 0 for die 0) and 0 elsewhere. Otherwise `ready` is 0.
- R8: A command byte other than the four codes sets the die's `err` bit and returns the die to idle. The `err` bit stays set until reset.
- R9: An address byte (`ale` 1, `cle` 0) arriving while the die is idle, or as a fourth address byte, sets the die's `err` bit and returns the die to idle. The pointer is left unchanged.
- R10: After reset, array byte a of die d holds 0xFF when PRELOAD is 0. When PRELOAD is 1 it holds (a mod 256 + (a div 256)×37 + d×90) mod 256.
- R11: The two dies are independent. Commands, addresses, reads and errors on one die leave the other die's pointer and `err` bit unchanged.
- R12: Any read-mode command clears the address-cycle counter, so a fresh sequence of three address bytes is accepted after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 2 | Active-low die enables, bit 0 has priority |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Active-low write strobe, latches on rising edge |
| re_n | input | 1 | Active-low read strobe, advances pointer on rising edge |
| din | input | 8 | Host-to-device data byte |
| dout | output | 8 | Device-to-host read data |
| dout_en | output | 1 | Device drives the data lines |
| ready | output | 2 | Per-die ready indication |
| err | output | 2 | Per-die sticky protocol error flag |

## Verification
The checker watches several properties on every clock. `ready` never flags both dies at once, and `dout_en` never coincides with `ready`. An `err` bit never clears without reset. Each pointer stays below N, and every read strobe moves the pointer by exactly one with wrap. The actual values are shown only by the bench's scenarios, which sweep both dies, all three modes and a grid of address bytes against arithmetically computed data. These scenarios also show the page and column weighting, the wrap at the array end, the handling of unknown commands and illegal address cycles, and the priority and independence of the two dies.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;

    localparam int unsigned PAGE_BYTES = 528;
    localparam int unsigned NUM_DIES   = 2;
    localparam int unsigned HI_PAGES   = 256;

    localparam logic [7:0] CMD_RESET = 8'hFF;
    localparam logic [7:0] CMD_LO    = 8'h00;
    localparam logic [7:0] CMD_MID   = 8'h01;
    localparam logic [7:0] CMD_HI    = 8'h50;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_READ_LO  = 2'd1,
        ST_READ_MID = 2'd2,
        ST_READ_HI  = 2'd3
    } rd_state_t;

    // Priority die select from active-low enables: die 0 wins.
    function automatic logic [1:0] pick_die(input logic [1:0] en_n);
        logic [1:0] sel;
        sel = 2'b00;
        if (!en_n[0]) begin
            sel = 2'b01;
        end else if (!en_n[1]) begin
            sel = 2'b10;
        end
        return sel;
    endfunction

    // Reset content of one array byte.
    function automatic logic [7:0] fill_byte(input bit preload,
                                             input int unsigned die,
                                             input int unsigned a);
        int unsigned v;
        v = a + (a >> 8) * 37 + die * 90;
        return preload ? v[7:0] : 8'hFF;
    endfunction

endpackage

// File: rtl/nand_rd_sync.sv
module nand_rd_sync (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ce_n,
    input  logic       cle,
    input  logic       ale,
    input  logic       we_n,
    input  logic       re_n,
    input  logic [7:0] din,
    // current synchronized level
    output logic [1:0] cur_ce_n,
    output logic       cur_cle,
    output logic       cur_ale,
    output logic       cur_we_n,
    output logic       cur_re_n,
    // level one cycle earlier, used for edge events
    output logic [1:0] prv_ce_n,
    output logic       prv_cle,
    output logic       prv_ale,
    output logic [7:0] prv_data,
    output logic       wr_rise,
    output logic       rd_rise
);

    typedef struct packed {
        logic [1:0] ce_n;
        logic       cle;
        logic       ale;
        logic       we_n;
        logic       re_n;
        logic [7:0] data;
    } bus_t;

    localparam bus_t BUS_IDLE = '{ce_n: 2'b11, cle: 1'b0, ale: 1'b0,
                                  we_n: 1'b1, re_n: 1'b1, data: 8'h00};

    bus_t meta_q, cur_q, prv_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= BUS_IDLE;
            cur_q  <= BUS_IDLE;
            prv_q  <= BUS_IDLE;
        end else begin
            meta_q <= '{ce_n: ce_n, cle: cle, ale: ale,
                        we_n: we_n, re_n: re_n, data: din};
            cur_q  <= meta_q;
            prv_q  <= cur_q;
        end
    end

    always_comb begin
        cur_ce_n = cur_q.ce_n;
        cur_cle  = cur_q.cle;
        cur_ale  = cur_q.ale;
        cur_we_n = cur_q.we_n;
        cur_re_n = cur_q.re_n;
        prv_ce_n = prv_q.ce_n;
        prv_cle  = prv_q.cle;
        prv_ale  = prv_q.ale;
        prv_data = prv_q.data;
        wr_rise  = cur_q.we_n & ~prv_q.we_n;
        rd_rise  = cur_q.re_n & ~prv_q.re_n;
    end

endmodule

// File: rtl/nand_rd_die.sv
module nand_rd_die
    import nand_rd_pkg::*;
#(
    parameter int unsigned ARRAY_BYTES = 3 * 528,
    parameter int unsigned PTR_W       = 11,
    parameter int unsigned DIE_ID      = 0,
    parameter bit          PRELOAD     = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_stb,
    input  logic             addr_stb,
    input  logic             rd_stb,
    input  logic [7:0]       bus_byte,
    output logic [7:0]       rdata,
    output logic [PTR_W-1:0] ptr,
    output logic             err
);

    localparam logic [31:0] N_BYTES   = 32'(ARRAY_BYTES);
    localparam logic [31:0] STEP_PAGE = 32'(PAGE_BYTES % ARRAY_BYTES);
    localparam logic [31:0] STEP_HI   = 32'((PAGE_BYTES * HI_PAGES) % ARRAY_BYTES);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(ARRAY_BYTES - 1);

    rd_state_t        st_q, st_d;
    logic [1:0]       cnt_q, cnt_d;
    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic             err_q, err_set;
    logic [31:0]      col;
    logic [31:0]      acc;
    logic [7:0]       mem [ARRAY_BYTES];

    // Storage: loaded at reset, never written afterwards.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(ARRAY_BYTES); i++) begin
                mem[i] <= fill_byte(PRELOAD, DIE_ID, i);
            end
        end
    end

    always_comb begin
        unique case (st_q)
            ST_READ_MID: col = 32'd256;
            ST_READ_HI:  col = 32'd512;
            default:     col = 32'd0;
        endcase
    end

    // Next-state and pointer logic.
    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        ptr_d   = ptr_q;
        err_set = 1'b0;
        acc     = 32'd0;
        if (cmd_stb) begin
            unique case (bus_byte)
                CMD_RESET: st_d = ST_IDLE;
                CMD_LO: begin
                    st_d  = ST_READ_LO;
                    cnt_d = 2'd0;
                end
                CMD_MID: begin
                    st_d  = ST_READ_MID;
                    cnt_d = 2'd0;
                end
                CMD_HI: begin
                    st_d  = ST_READ_HI;
                    cnt_d = 2'd0;
                end
                default: begin
                    st_d    = ST_IDLE;
                    err_set = 1'b1;
                end
            endcase
        end else if (addr_stb) begin
            if (st_q == ST_IDLE || cnt_q == 2'd3) begin
                st_d    = ST_IDLE;
                err_set = 1'b1;
            end else begin
                unique case (cnt_q)
                    2'd0:    acc = 32'(bus_byte) | col;
                    2'd1:    acc = 32'(ptr_q) + 32'(bus_byte) * STEP_HI;
                    default: acc = 32'(ptr_q) + 32'(bus_byte) * STEP_PAGE;
                endcase
                acc   = acc % N_BYTES;
                ptr_d = acc[PTR_W-1:0];
                cnt_d = cnt_q + 2'd1;
            end
        end else if (rd_stb) begin
            ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= 2'd0;
            ptr_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            ptr_q <= ptr_d;
        end
    end

    // Outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (err_set) begin
            err_q <= 1'b1;
        end
    end

    always_comb begin
        rdata = mem[ptr_q];
        ptr   = ptr_q;
        err   = err_q;
    end

endmodule

// File: rtl/nand_rd_target.sv
module nand_rd_target
    import nand_rd_pkg::*;
#(
    parameter int unsigned PAGES   = 3,
    parameter bit          PRELOAD = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ce_n,
    input  logic       cle,
    input  logic       ale,
    input  logic       we_n,
    input  logic       re_n,
    input  logic [7:0] din,
    output logic [7:0] dout,
    output logic       dout_en,
    output logic [1:0] ready,
    output logic [1:0] err
);

    localparam int unsigned ARRAY_BYTES = PAGES * PAGE_BYTES;
    localparam int unsigned PTR_W       = $clog2(ARRAY_BYTES);

    logic [1:0] cur_ce_n, prv_ce_n;
    logic       cur_cle, cur_ale, cur_we_n, cur_re_n;
    logic       prv_cle, prv_ale;
    logic [7:0] prv_data;
    logic       wr_rise, rd_rise;

    logic [1:0] sel_cur, sel_prv;
    logic [NUM_DIES-1:0] cmd_stb, addr_stb, rd_stb, wr_stb;
    logic [NUM_DIES-1:0][7:0]       die_data;
    logic [NUM_DIES-1:0][PTR_W-1:0] die_ptr;
    logic [NUM_DIES-1:0]            die_err;

    nand_rd_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .cle      (cle),
        .ale      (ale),
        .we_n     (we_n),
        .re_n     (re_n),
        .din      (din),
        .cur_ce_n (cur_ce_n),
        .cur_cle  (cur_cle),
        .cur_ale  (cur_ale),
        .cur_we_n (cur_we_n),
        .cur_re_n (cur_re_n),
        .prv_ce_n (prv_ce_n),
        .prv_cle  (prv_cle),
        .prv_ale  (prv_ale),
        .prv_data (prv_data),
        .wr_rise  (wr_rise),
        .rd_rise  (rd_rise)
    );

    always_comb begin
        sel_cur  = pick_die(cur_ce_n);
        sel_prv  = pick_die(prv_ce_n);
        cmd_stb  = {NUM_DIES{wr_rise & prv_cle}} & sel_prv;
        addr_stb = {NUM_DIES{wr_rise & ~prv_cle & prv_ale}} & sel_prv;
        rd_stb   = {NUM_DIES{rd_rise & ~prv_cle & ~prv_ale}} & sel_prv;
        wr_stb   = cmd_stb | addr_stb;
    end

    for (genvar g = 0; g < NUM_DIES; g++) begin : g_die
        nand_rd_die #(
            .ARRAY_BYTES (ARRAY_BYTES),
            .PTR_W       (PTR_W),
            .DIE_ID      (g),
            .PRELOAD     (PRELOAD)
        ) u_die (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmd_stb  (cmd_stb[g]),
            .addr_stb (addr_stb[g]),
            .rd_stb   (rd_stb[g]),
            .bus_byte (prv_data),
            .rdata    (die_data[g]),
            .ptr      (die_ptr[g]),
            .err      (die_err[g])
        );
    end

    // Bus-facing outputs.
    always_comb begin
        dout_en = (|sel_cur) & ~cur_re_n & ~cur_cle & ~cur_ale;
        dout    = 8'h00;
        if (dout_en) begin
            dout = sel_cur[1] ? die_data[1] : die_data[0];
        end
        ready = sel_cur & {2{cur_re_n & cur_we_n}};
        err   = die_err;
    end

endmodule

// File: rtl/nand_rd_target_chk.sv
module nand_rd_target_chk #(
    parameter int unsigned ARRAY_BYTES = 3 * 528,
    parameter int unsigned PTR_W       = 11
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  dout_en,
    input logic [1:0]            ready,
    input logic [1:0]            err,
    input logic [1:0][PTR_W-1:0] die_ptr,
    input logic [1:0]            rd_stb,
    input logic [1:0]            wr_stb
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(ARRAY_BYTES - 1);

    // R1, R7: the die priority never flags both dies ready.
    p_ready_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ready));

    // R6: driving data and signalling ready never coincide.
    p_drive_vs_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(dout_en && (|ready)));

    // R8: error flags are sticky.
    p_err0_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err[0] |=> err[0]);
    p_err1_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err[1] |=> err[1]);

    // R4: pointers stay inside the array.
    p_ptr0_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        die_ptr[0] <= LAST);
    p_ptr1_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        die_ptr[1] <= LAST);

    // R5: a read strobe advances the pointer by one with wrap.
    p_ptr0_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb[0] && !wr_stb[0]) |=>
        die_ptr[0] == (($past(die_ptr[0]) == LAST) ? '0 : $past(die_ptr[0]) + 1'b1));
    p_ptr1_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb[1] && !wr_stb[1]) |=>
        die_ptr[1] == (($past(die_ptr[1]) == LAST) ? '0 : $past(die_ptr[1]) + 1'b1));

endmodule

bind nand_rd_target nand_rd_target_chk #(
    .ARRAY_BYTES (ARRAY_BYTES),
    .PTR_W       (PTR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .dout_en (dout_en),
    .ready   (ready),
    .err     (err),
    .die_ptr (die_ptr),
    .rd_stb  (rd_stb),
    .wr_stb  (wr_stb)
);

// File: tb/tb_nand_rd_target.sv
module tb_nand_rd_target;

    localparam int unsigned NB = 3 * 528;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ce_n = 2'b11;
    logic       cle = 1'b0;
    logic       ale = 1'b0;
    logic       we_n = 1'b1;
    logic       re_n = 1'b1;
    logic [7:0] din = 8'h00;
    logic [7:0] dout, dout_e;
    logic       dout_en, dout_en_e;
    logic [1:0] ready, ready_e, err, err_e;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    nand_rd_target #(.PAGES(3), .PRELOAD(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
        .we_n(we_n), .re_n(re_n), .din(din), .dout(dout),
        .dout_en(dout_en), .ready(ready), .err(err)
    );

    nand_rd_target #(.PAGES(3), .PRELOAD(1'b0)) dut_erased (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
        .we_n(we_n), .re_n(re_n), .din(din), .dout(dout_e),
        .dout_en(dout_en_e), .ready(ready_e), .err(err_e)
    );

    function automatic int unsigned ref_addr(int m, int unsigned b0,
                                             int unsigned b1, int unsigned b2);
        int unsigned c;
        c = (m == 0) ? 0 : (m == 1) ? 256 : 512;
        return ((b0 + c) + b1 * 528 * 256 + b2 * 528) % NB;
    endfunction

    function automatic int unsigned ref_byte(int d, int unsigned a);
        return ((a % 256) + (a / 256) * 37 + d * 90) % 256;
    endfunction

    function automatic logic [1:0] en_for(int d);
        return (d == 0) ? 2'b10 : 2'b01;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic clocks(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic do_reset();
        ce_n = 2'b11; cle = 0; ale = 0; we_n = 1; re_n = 1;
        rst_n = 0;
        clocks(3);
        rst_n = 1;
        clocks(3);
    endtask

    task automatic bus_wr(logic [1:0] en, bit is_cmd, logic [7:0] b);
        ce_n = en; cle = is_cmd; ale = !is_cmd; din = b;
        clocks(3);
        we_n = 0;
        clocks(4);
        we_n = 1;
        clocks(4);
        cle = 0; ale = 0;
        clocks(1);
    endtask

    task automatic bus_rd(logic [1:0] en, output int v, output int oe, output int ve);
        ce_n = en;
        clocks(2);
        re_n = 0;
        clocks(4);
        @(negedge clk);
        v = dout; oe = dout_en; ve = dout_e;
        re_n = 1;
        clocks(4);
    endtask

    task automatic set_ptr(int d, int m, int b0, int b1, int b2);
        logic [7:0] c;
        c = (m == 0) ? 8'h00 : (m == 1) ? 8'h01 : 8'h50;
        bus_wr(en_for(d), 1'b1, c);
        bus_wr(en_for(d), 1'b0, 8'(b0));
        bus_wr(en_for(d), 1'b0, 8'(b1));
        bus_wr(en_for(d), 1'b0, 8'(b2));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v, oe, ve;
        int unsigned a;
        do_reset();
        @(negedge clk);
        // Reset state: nothing driven, no ready, no error (R6, R7, R8).
        chk("R6 reset dout_en", dout_en, 0);
        chk("R7 reset ready", ready, 0);
        chk("R8 reset err", err, 0);

        // Ready per die with strobes idle (R7, R1 priority).
        ce_n = 2'b10; clocks(4); @(negedge clk);
        chk("R7 ready die0", ready, 2'b01);
        ce_n = 2'b01; clocks(4); @(negedge clk);
        chk("R7 ready die1", ready, 2'b10);
        ce_n = 2'b00; clocks(4); @(negedge clk);
        chk("R1 priority die0", ready, 2'b01);
        ce_n = 2'b11; clocks(4); @(negedge clk);
        chk("R1 none selected ready", ready, 0);

        // Sweep: dies, modes, address grid (R2, R3, R4, R5, R6, R10).
        for (int d = 0; d < 2; d++) begin
            for (int m = 0; m < 3; m++) begin
                for (int i0 = 0; i0 < 3; i0++) begin
                    for (int i1 = 0; i1 < 3; i1++) begin
                        for (int i2 = 0; i2 < 3; i2++) begin
                            int b0;
                            b0 = (i0 == 0) ? 0 : (i0 == 1) ? 7 : 255;
                            set_ptr(d, m, b0, i1, i2);
                            a = ref_addr(m, b0, i1, i2);
                            bus_rd(en_for(d), v, oe, ve);
                            chk("R3 R4 first byte", v, ref_byte(d, a));
                            chk("R6 dout_en on read", oe, 1);
                            chk("R10 erased content", ve, 8'hFF);
                            bus_rd(en_for(d), v, oe, ve);
                            chk("R5 next byte", v, ref_byte(d, (a + 1) % NB));
                        end
                    end
                end
            end
        end
        chk("R2 no error after sweep", err, 0);

        // Wrap at array end on die 1 (R5).
        set_ptr(1, 0, 255, 0, 2);
        a = 255 + 2 * 528;
        for (int k = 0; k < 280; k++) begin
            bus_rd(en_for(1), v, oe, ve);
            chk("R5 wrap read", v, ref_byte(1, (a + k) % NB));
        end

        // Unselected bus is ignored (R1), dies independent (R11).
        set_ptr(0, 1, 3, 0, 0);
        set_ptr(1, 2, 0, 0, 0);
        bus_rd(en_for(0), v, oe, ve);
        chk("R3 mid column", v, ref_byte(0, 259));
        bus_wr(2'b11, 1'b0, 8'h09);
        bus_wr(2'b11, 1'b1, 8'hFF);
        bus_rd(2'b11, v, oe, ve);
        chk("R1 unselected no drive", oe, 0);
        chk("R6 unselected dout zero", v, 0);
        bus_rd(en_for(0), v, oe, ve);
        chk("R1 die0 pointer kept", v, ref_byte(0, 260));
        bus_rd(en_for(1), v, oe, ve);
        chk("R11 die1 pointer kept", v, ref_byte(1, 512));
        chk("R1 no error when unselected", err, 0);

        // Read-mode command restarts address counting (R12).
        bus_wr(en_for(0), 1'b1, 8'h00);
        bus_wr(en_for(0), 1'b0, 8'h01);
        bus_wr(en_for(0), 1'b0, 8'h01);
        set_ptr(0, 2, 4, 0, 1);
        @(negedge clk);
        chk("R12 no error on restart", err, 0);
        bus_rd(en_for(0), v, oe, ve);
        chk("R12 restarted pointer", v, ref_byte(0, 516 + 528));

        // Unknown command (R8, R11).
        do_reset();
        bus_wr(en_for(1), 1'b1, 8'h00);
        bus_wr(en_for(1), 1'b0, 8'h05);
        bus_wr(en_for(1), 1'b1, 8'h33);
        @(negedge clk);
        chk("R8 unknown cmd err", err, 2'b10);
        set_ptr(1, 0, 1, 0, 0);
        @(negedge clk);
        chk("R8 err sticky", err, 2'b10);
        set_ptr(0, 0, 2, 0, 0);
        bus_rd(en_for(0), v, oe, ve);
        chk("R11 die0 unaffected", v, ref_byte(0, 2));
        chk("R11 die0 err clear", err, 2'b10);

        // Address while idle after 0xFF (R2, R9).
        do_reset();
        bus_wr(en_for(0), 1'b1, 8'h00);
        bus_wr(en_for(0), 1'b1, 8'hFF);
        @(negedge clk);
        chk("R2 reset cmd no err", err, 0);
        bus_wr(en_for(0), 1'b0, 8'h10);
        @(negedge clk);
        chk("R9 idle address err", err, 2'b01);

        // Fourth address byte (R9), pointer untouched.
        do_reset();
        set_ptr(1, 0, 20, 0, 1);
        @(negedge clk);
        chk("R9 three bytes legal", err, 0);
        bus_wr(en_for(1), 1'b0, 8'h03);
        @(negedge clk);
        chk("R9 fourth byte err", err, 2'b10);
        bus_rd(en_for(1), v, oe, ve);
        chk("R9 pointer unchanged", v, ref_byte(1, 548));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule